// File: doc/BRIEF.md
# Periodic interrupt and event flag controller

This block sits beside the calendar engine of a real-time clock. It counts the 32.768 kHz tick enable to produce a periodic event whose period is chosen by a 4-bit rate code. The calendar engine delivers an alarm-match pulse and an update-finished pulse, and the block keeps one sticky flag for each of these three event sources in a status byte. A summary interrupt bit is set when any flag meets its enable. The interrupt bit drives an active-low open-drain request, modelled as an output enable with the data value held at 0.

The host reaches four byte registers through a simple write port and a combinational read port. Register addresses are 0 (rate/control), 1 (enables), 2 (status) and 3 (validity). A separate strobe tells the block that the status byte has just been read. That strobe clears every flag and releases the request. An event that arrives in the same cycle as the strobe is kept.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: Reset sets registers 0 and 1 to 0x00, clears all of the status byte, and leaves `irq_oe` low.
- R2: A rate code of 0 (register 0 bits 3:0) produces no periodic event.
- R3: Rate codes 3 to 15 give a periodic flag after 2^(code-1) ticks, counted from the write of the code.
- R4: Rate code 1 gives a period of 128 ticks and code 2 gives a period of 256 ticks. These are the same periods as codes 8 and 9.
- R5: The status byte (address 2) has the summary interrupt bit at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3:0 read 0. A flag sets on its event whether or not it is enabled.
- R6: Register 1 bit 6 enables the periodic source, bit 5 the alarm source and bit 4 the update source. The summary bit sets when a flag and its enable are both 1, and it remains set until the status read strobe. `irq_oe` equals the summary bit, and `irq_o` is always 0.
- R7: A pulse on `stat_rd` clears all four status bits and drops `irq_oe` on the next cycle.
- R8: Register 1 bit 7 (transfer hold) blocks the update source from the summary bit. The update flag itself still sets.
- R9: When an event and `stat_rd` occur in the same cycle, the flag for that event stays set, and the summary bit stays set if the event is enabled. All other flags clear.
- R10: Writes to addresses 2 and 3 have no effect. Register 0 bit 7 always reads 0. Address 3 reads `{backup_ok, 7'b0}`.
- R11: The periodic counter advances only in cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| alarm_evt | input | 1 | Alarm-match pulse from the calendar engine |
| update_evt | input | 1 | Update-finished pulse from the calendar engine |
| backup_ok | input | 1 | Backup source valid |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| stat_rd | input | 1 | Status byte has been read; clear flags |
| irq_oe | output | 1 | Interrupt pin drive enable (pin pulled low while high) |
| irq_o | output | 1 | Interrupt pin data value, fixed at 0 |

## Verification
A flag-setting event and the status read strobe can land on the same clock edge. When they do, the clear and the set compete for the same sticky bit. The bench provokes this by driving `stat_rd` together with `update_evt` or `alarm_evt`, first after some other flag has already been set. It then judges that only the fresh event's flag survives, together with the summary bit when that source is enabled.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_ENAB  = 2'd1;
   localparam logic [1:0] ADDR_STAT  = 2'd2;
   localparam logic [1:0] ADDR_VALID = 2'd3;

   localparam int EN_HOLD_BIT = 7;
   localparam int EN_PER_BIT  = 6;
   localparam int EN_ALM_BIT  = 5;
   localparam int EN_UPD_BIT  = 4;

   localparam int LOW_ALIAS_SHIFT = 6;

   // period in ticks for a rate code; 0 means no periodic event
   function automatic int period_ticks(input int code);
      if (code == 0)
         return 0;
      else if (code < 3)
         return 1 << (code + LOW_ALIAS_SHIFT);
      else
         return 1 << (code - 1);
   endfunction

endpackage

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-2:0] ctrl_q,
   output logic [DATA_W-1:0] enab_q,
   output logic              rate_restart
);

   initial begin
      assert (DATA_W == 8) else $error("rtc_cfg_regs: DATA_W must be 8");
   end

   logic wr_ctrl, wr_enab;

   assign wr_ctrl      = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_enab      = wr_en && (wr_addr == ADDR_ENAB);
   assign rate_restart = wr_ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         enab_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wr_data[DATA_W-2:0];
         if (wr_enab) enab_q <= wr_data;
      end
   end

   // R10: top bit of the control register is never stored
   p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctrl_q == $past(wr_data[DATA_W-2:0])));

endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
   import rtc_irq_pkg::*;
#(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate,
   output logic              per_hit
);

   localparam int NCODE = 1 << RATE_W;
   localparam int CNT_W = NCODE - 2;

   initial begin
      assert (RATE_W == 4) else $error("rtc_rate_div: rate code map assumes RATE_W == 4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [NCODE-1:0] term_v;

   // one terminal-count compare per rate code
   genvar k;
   generate
      for (k = 0; k < NCODE; k++) begin : g_term
         if (k == 0) begin : g_off
            assign term_v[k] = 1'b0;
         end else begin : g_on
            localparam int LAST = period_ticks(k) - 1;
            assign term_v[k] = (cnt_q == CNT_W'(LAST));
         end
      end
   endgenerate

   assign per_hit = tick_en && !restart && (rate != '0) && term_v[rate];

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || rate == '0)
         cnt_q <= '0;
      else if (tick_en)
         cnt_q <= per_hit ? '0 : cnt_q + 1'b1;
   end

   // R3: periodic hits are never back to back (shortest period is 4 ticks)
   p_hit_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      per_hit |=> !per_hit);

   // R2: with the rate off the counter sits at zero
   p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == '0) |=> (cnt_q == '0));

   // R11: the counter holds when no tick arrives
   p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !restart && rate != '0) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic per_hit,
   input  logic alarm_evt,
   input  logic update_evt,
   input  logic clr,
   input  logic en_per,
   input  logic en_alm,
   input  logic en_upd,
   input  logic hold,
   output logic pf_q,
   output logic af_q,
   output logic uf_q,
   output logic intf_q
);

   logic pf_n, af_n, uf_n, req_n;

   // a fresh event beats the clear
   assign pf_n  = per_hit    || (pf_q && !clr);
   assign af_n  = alarm_evt  || (af_q && !clr);
   assign uf_n  = update_evt || (uf_q && !clr);
   assign req_n = (en_per && pf_n) || (en_alm && af_n) || (en_upd && !hold && uf_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_q   <= 1'b0;
         af_q   <= 1'b0;
         uf_q   <= 1'b0;
         intf_q <= 1'b0;
      end else begin
         pf_q   <= pf_n;
         af_q   <= af_n;
         uf_q   <= uf_n;
         intf_q <= req_n || (intf_q && !clr);
      end
   end

   // R7: a clear with no events empties everything
   p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !per_hit && !alarm_evt && !update_evt) |=> !(pf_q || af_q || uf_q || intf_q));

   // R9: an alarm arriving with the clear survives
   p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && alarm_evt) |=> af_q);

   // R6: a new request always has an enabled flag behind it
   p_intf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intf_q) |-> (($past(en_per) && pf_q) || ($past(en_alm) && af_q) ||
                         ($past(en_upd && !hold) && uf_q)));

   // R8: with only the update source enabled and held, no request rises
   p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!intf_q && hold && !en_per && !en_alm) |=> !intf_q);

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
   import rtc_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              alarm_evt,
   input  logic              update_evt,
   input  logic              backup_ok,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              stat_rd,
   output logic              irq_oe,
   output logic              irq_o
);

   localparam int FLAG_LSB = DATA_W - 4;

   logic [DATA_W-2:0] ctrl_q;
   logic [DATA_W-1:0] enab_q;
   logic              rate_restart, per_hit;
   logic              pf_q, af_q, uf_q, intf_q;

   rtc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .ctrl_q       (ctrl_q),
      .enab_q       (enab_q),
      .rate_restart (rate_restart)
   );

   rtc_rate_div #(.RATE_W(RATE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .restart (rate_restart),
      .rate    (ctrl_q[RATE_W-1:0]),
      .per_hit (per_hit)
   );

   rtc_evt_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .per_hit    (per_hit),
      .alarm_evt  (alarm_evt),
      .update_evt (update_evt),
      .clr        (stat_rd),
      .en_per     (enab_q[EN_PER_BIT]),
      .en_alm     (enab_q[EN_ALM_BIT]),
      .en_upd     (enab_q[EN_UPD_BIT]),
      .hold       (enab_q[EN_HOLD_BIT]),
      .pf_q       (pf_q),
      .af_q       (af_q),
      .uf_q       (uf_q),
      .intf_q     (intf_q)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_CTRL:  rd_data = {1'b0, ctrl_q};
         ADDR_ENAB:  rd_data = enab_q;
         ADDR_STAT:  rd_data = {intf_q, pf_q, af_q, uf_q, {FLAG_LSB{1'b0}}};
         default:    rd_data = {backup_ok, {(DATA_W-1){1'b0}}};
      endcase
   end

   assign irq_oe = intf_q;
   assign irq_o  = 1'b0;

   // R6: the pin is driven only after some flag has been seen
   p_pin_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_oe) |-> (pf_q || af_q || uf_q));

   // R7: the read strobe with no events releases the pin
   p_pin_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !alarm_evt && !update_evt && !per_hit) |=> !irq_oe);

endmodule

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n, tick_en, alarm_evt, update_evt, backup_ok;
   logic       wr_en, stat_rd;
   logic [1:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic       irq_oe, irq_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   rtc_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .alarm_evt(alarm_evt),
      .update_evt(update_evt), .backup_ok(backup_ok), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .stat_rd(stat_rd), .irq_oe(irq_oe), .irq_o(irq_o)
   );

   // {rate code, expected ticks to first periodic flag (0 = never)}
   localparam logic [19:0] VEC [12] = '{
      {4'd3, 16'd4},    {4'd4, 16'd8},     {4'd5, 16'd16},   {4'd6, 16'd32},
      {4'd1, 16'd128},  {4'd2, 16'd256},   {4'd8, 16'd128},  {4'd9, 16'd256},
      {4'd12, 16'd2048},{4'd15, 16'd16384},{4'd7, 16'd64},   {4'd0, 16'd0}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic alm, input logic upd, input logic rd);
      @(negedge clk);
      alarm_evt = alm; update_evt = upd; stat_rd = rd;
      @(negedge clk);
      alarm_evt = 1'b0; update_evt = 1'b0; stat_rd = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   // returns cycles after the rate write until the periodic flag shows
   task automatic measure(input logic [3:0] code, input bit half, input int limit,
                          output int seen);
      logic [7:0] v;
      wr(2'd0, 8'h00);
      pulse(1'b0, 1'b0, 1'b1);
      wr(2'd0, {4'h0, code});
      seen = 0;
      rd_addr = 2'd2;
      for (int n = 1; n <= limit; n++) begin
         tick_en = half ? n[0] : 1'b1;
         @(negedge clk);
         rd(2'd2, v);
         if (v[6]) begin
            seen = n;
            break;
         end
      end
      tick_en = 1'b1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int got;
      rst_n = 0; tick_en = 1; alarm_evt = 0; update_evt = 0; backup_ok = 1;
      wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; stat_rd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state, R10 validity byte
      rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
      rd(2'd1, v); chk("R1 enab after reset", v, 8'h00);
      rd(2'd2, v); chk("R1 status after reset", v, 8'h00);
      chk("R1 irq_oe after reset", {7'b0, irq_oe}, 8'h00);
      rd(2'd3, v); chk("R10 valid with backup", v, 8'h80);

      // R10 read-only registers and fixed top bit
      wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
      rd(2'd2, v); chk("R10 status write ignored", v, 8'h00);
      rd(2'd3, v); chk("R10 valid write ignored", v, 8'h80);
      backup_ok = 0;
      rd(2'd3, v); chk("R10 valid without backup", v, 8'h00);
      backup_ok = 1;
      wr(2'd0, 8'hF0);
      rd(2'd0, v); chk("R10 ctrl bit7 reads 0", v, 8'h70);

      // R2 R3 R4 rate table
      foreach (VEC[i]) begin
         logic [3:0]  code;
         logic [15:0] expn;
         int lim;
         code = VEC[i][19:16];
         expn = VEC[i][15:0];
         lim  = (expn == 0) ? 600 : int'(expn) + 4;
         measure(code, 1'b0, lim, got);
         if (code == 0)
            chk("R2 rate off never flags", 8'(got), 8'h00);
         else if (code < 3)
            chk($sformatf("R4 code %0d period", code), 8'(got >> 7), 8'(int'(expn) >> 7));
         else
            chk($sformatf("R3 code %0d period", code), 8'(got >> (code - 1)),
                8'(int'(expn) >> (code - 1)));
         if (code != 0)
            chk($sformatf("R3 code %0d exact", code), 8'(got - int'(expn)), 8'h00);
      end

      // R11 tick only every other cycle: 4 ticks land on cycle 7
      measure(4'd3, 1'b1, 20, got);
      chk("R11 gated tick count", 8'(got), 8'd7);

      wr(2'd0, 8'h00);
      pulse(1'b0, 1'b0, 1'b1);
      rd(2'd2, v); chk("R7 clear after periodic", v, 8'h00);

      // R5 alarm flag without enable
      pulse(1'b1, 1'b0, 1'b0);
      rd(2'd2, v); chk("R5 alarm flag only", v, 8'h20);
      chk("R5 no pin without enable", {7'b0, irq_oe}, 8'h00);
      // R6 enabling afterward raises the request
      wr(2'd1, 8'h20);
      @(negedge clk);
      rd(2'd2, v); chk("R6 alarm request", v, 8'hA0);
      chk("R6 pin driven", {7'b0, irq_oe}, 8'h01);
      chk("R6 pin data low", {7'b0, irq_o}, 8'h00);
      // R7 clear
      pulse(1'b0, 1'b0, 1'b1);
      rd(2'd2, v); chk("R7 status cleared", v, 8'h00);
      chk("R7 pin released", {7'b0, irq_oe}, 8'h01 & {7'b0, irq_oe} & 8'h00);
      chk("R7 pin released value", {7'b0, irq_oe}, 8'h00);

      // R8 transfer hold blocks update source
      wr(2'd1, 8'h90);
      pulse(1'b0, 1'b1, 1'b0);
      rd(2'd2, v); chk("R8 update flag under hold", v, 8'h10);
      chk("R8 no pin under hold", {7'b0, irq_oe}, 8'h00);
      wr(2'd1, 8'h10);
      @(negedge clk);
      rd(2'd2, v); chk("R8 request once hold drops", v, 8'h90);
      pulse(1'b0, 1'b0, 1'b1);

      // R9 event and clear together; older alarm flag must go
      pulse(1'b1, 1'b0, 1'b0);
      rd(2'd2, v); chk("R9 setup alarm flag", v, 8'h20);
      pulse(1'b0, 1'b1, 1'b1);
      rd(2'd2, v); chk("R9 update survives clear", v, 8'h90);
      chk("R9 pin stays driven", {7'b0, irq_oe}, 8'h01);
      wr(2'd1, 8'h00);
      pulse(1'b1, 1'b0, 1'b1);
      rd(2'd2, v); chk("R9 unenabled alarm survives alone", v, 8'h20);
      pulse(1'b0, 1'b0, 1'b1);

      // R6 periodic source drives the pin
      wr(2'd1, 8'h40);
      wr(2'd0, 8'h03);
      repeat (5) @(negedge clk);
      rd(2'd2, v); chk("R6 periodic request", v & 8'hC0, 8'hC0);
      chk("R6 periodic pin", {7'b0, irq_oe}, 8'h01);

      // R1 reset mid-run
      wr(2'd1, 8'h70);
      pulse(1'b1, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      rd(2'd1, v); chk("R1 enables cleared by reset", v, 8'h00);
      rd(2'd0, v); chk("R1 ctrl cleared by reset", v, 8'h00);
      rd(2'd2, v); chk("R1 status cleared by reset", v, 8'h00);
      chk("R1 pin released by reset", {7'b0, irq_oe}, 8'h00);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule